// File: doc/BRIEF.md
# Vector Lane Byte Transfer Unit

This unit moves a short run of bytes (one, two, four or eight) between a byte-addressed data memory and one register of a small vector register file. Each vector register is 128 bits wide, seen as eight 16-bit lanes stored big-endian. An already decoded command supplies the direction, the access size, a base value, a small signed offset, the vector register number and a byte position inside that register. The unit forms the memory address and then transfers one byte per clock through a synchronous single-byte memory port.

On a load, bytes read from memory are written into consecutive byte positions of the chosen register. On a store, consecutive register bytes are written out to memory. The offset is counted in units of the access size. A word or doubleword access that starts inside one lane keeps going into the lanes after it. A separate read port lets the surrounding datapath see the whole contents of any register.

Top module: `vlx_top`

## Requirements
- R1: The first memory address of an operation equals (base + sign-extended offset × size in bytes) modulo 4096. The offset is a 7-bit two's-complement value.
- R2: `op_size` codes 0, 1, 2 and 3 select 1, 2, 4 and 8 bytes. An operation makes exactly that many memory accesses (`mem_re` or `mem_we` cycles).
- R3: A load writes memory byte addr+k into register byte position elem+k. Register byte 0 is `rf_rd_data[127:120]`, and byte b is bits [127-8b -: 8]. Lane n is bytes 2n (high) and 2n+1 (low), so a halfword with elem 4 fills lane 2.
- R4: On a load, register byte positions above 15 are discarded, and no byte wraps back to position 0.
- R5: A store writes register byte (elem+k) mod 16 to memory address addr+k.
- R6: Within an operation the memory address advances by one per access and wraps from 4095 to 0.
- R7: `busy` rises the cycle after an accepted `start`. It stays high for N+1 cycles on an N-byte load and N cycles on an N-byte store. `done` is then high for exactly one cycle, with `busy` low. Memory strobes occur only while `busy` is high.
- R8: Register bytes outside the written range and all other registers keep their values. A `start` seen while `busy` is high is ignored.
- R9: After reset every register byte is zero, and `busy`, `done`, `mem_re` and `mem_we` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation (ignored while busy) |
| op_store | input | 1 | 1 = register to memory, 0 = memory to register |
| op_size | input | 2 | Access size code: 0..3 for 1, 2, 4 or 8 bytes |
| base_val | input | 32 | Base address value |
| offset | input | 7 | Signed offset, counted in access-size units |
| vreg | input | 3 | Vector register number |
| elem | input | 4 | Starting byte position in the register |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| mem_addr | output | 12 | Memory byte address |
| mem_re | output | 1 | Memory read strobe; data returns the next cycle |
| mem_we | output | 1 | Memory write strobe |
| mem_wdata | output | 8 | Memory write byte |
| mem_rdata | input | 8 | Memory read byte, one cycle after `mem_re` |
| rf_rd_idx | input | 3 | Register number for the full-width read port |
| rf_rd_data | output | 128 | Contents of register `rf_rd_idx` |

## Verification
The hardest cases to reach are the two edge conditions at the ends of a transfer. One is a load whose byte positions run past the end of the register. The other is a store whose source positions wrap back to byte 0. Both need a large byte position combined with a wide access. Memory wrap needs a base and offset chosen so that the address crosses 4095, including through a negative offset from address zero. The vector table lines up each of these against a full register comparison and a check of memory around the touched range. A directed test raises `start` again one cycle into a running load, to show that the second command leaves no trace.

// File: rtl/vlx_pkg.sv
package vlx_pkg;

  typedef enum logic [1:0] {
    XSZ_BYTE  = 2'd0,
    XSZ_HALF  = 2'd1,
    XSZ_WORD  = 2'd2,
    XSZ_DWORD = 2'd3
  } xsize_e;

  typedef enum logic [1:0] {
    XST_IDLE  = 2'd0,
    XST_RUN   = 2'd1,
    XST_DRAIN = 2'd2
  } xstate_e;

  // number of bytes moved for a size code
  function automatic logic [3:0] size_bytes(input xsize_e s);
    return 4'd1 << s;
  endfunction

  // lowest bit of register byte b in a big-endian vector of rbytes bytes
  function automatic int byte_lsb(input int rbytes, input int b);
    return (rbytes - 1 - b) * 8;
  endfunction

endpackage

// File: rtl/vlx_addr_gen.sv
module vlx_addr_gen
  import vlx_pkg::*;
#(
  parameter int BASE_W = 32,
  parameter int OFF_W  = 7,
  parameter int MEM_AW = 12
) (
  input  logic [BASE_W-1:0] base_val,
  input  logic [OFF_W-1:0]  offset,
  input  xsize_e            size,
  output logic [MEM_AW-1:0] addr
);

  logic [BASE_W-1:0] off_ext;
  logic [BASE_W-1:0] off_scaled;
  logic [BASE_W-1:0] sum;
  logic              unused_hi;

  assign off_ext    = {{(BASE_W-OFF_W){offset[OFF_W-1]}}, offset};
  assign off_scaled = off_ext << size;
  assign sum        = base_val + off_scaled;
  assign addr       = sum[MEM_AW-1:0];
  assign unused_hi  = ^sum[BASE_W-1:MEM_AW];

endmodule

// File: rtl/vlx_seq.sv
module vlx_seq
  import vlx_pkg::*;
#(
  parameter int MEM_AW = 12,
  parameter int RIDX_W = 3,
  parameter int BIDX_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              op_store,
  input  xsize_e            op_size,
  input  logic [MEM_AW-1:0] start_addr,
  input  logic [RIDX_W-1:0] vreg,
  input  logic [BIDX_W-1:0] elem,
  input  logic [7:0]        rf_byte,
  input  logic [7:0]        mem_rdata,
  output logic              busy,
  output logic              done,
  output logic [MEM_AW-1:0] mem_addr,
  output logic              mem_re,
  output logic              mem_we,
  output logic [7:0]        mem_wdata,
  output logic [RIDX_W-1:0] src_reg,
  output logic [BIDX_W-1:0] src_byte,
  output logic              wr_en,
  output logic [RIDX_W-1:0] wr_reg,
  output logic [BIDX_W-1:0] wr_byte,
  output logic [7:0]        wr_data,
  output logic              accept,
  output logic [3:0]        nbytes,
  output logic              is_store
);

  localparam int POS_W = BIDX_W + 1;

  xstate_e           st_q;
  logic [3:0]        cnt_q;
  logic [3:0]        nbytes_q;
  logic              store_q;
  logic [MEM_AW-1:0] addr_q;
  logic [RIDX_W-1:0] reg_q;
  logic [BIDX_W-1:0] elem_q;
  logic              pend_v_q;
  logic [POS_W-1:0]  pend_pos_q;
  logic              done_q;

  logic              in_run;
  logic              last_xfer;
  logic [POS_W-1:0]  cur_pos;

  assign accept    = start && (st_q == XST_IDLE);
  assign in_run    = (st_q == XST_RUN);
  assign last_xfer = in_run && (cnt_q == nbytes_q - 4'd1);
  assign cur_pos   = {1'b0, elem_q} + POS_W'(cnt_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q       <= XST_IDLE;
      cnt_q      <= '0;
      nbytes_q   <= 4'd1;
      store_q    <= 1'b0;
      addr_q     <= '0;
      reg_q      <= '0;
      elem_q     <= '0;
      pend_v_q   <= 1'b0;
      pend_pos_q <= '0;
      done_q     <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (st_q)
        XST_IDLE: begin
          pend_v_q <= 1'b0;
          if (accept) begin
            st_q     <= XST_RUN;
            cnt_q    <= '0;
            nbytes_q <= size_bytes(op_size);
            store_q  <= op_store;
            addr_q   <= start_addr;
            reg_q    <= vreg;
            elem_q   <= elem;
          end
        end
        XST_RUN: begin
          cnt_q      <= cnt_q + 4'd1;
          pend_v_q   <= !store_q;
          pend_pos_q <= cur_pos;
          if (last_xfer) begin
            if (store_q) begin
              st_q   <= XST_IDLE;
              done_q <= 1'b1;
            end else begin
              st_q <= XST_DRAIN;
            end
          end
        end
        XST_DRAIN: begin
          pend_v_q <= 1'b0;
          st_q     <= XST_IDLE;
          done_q   <= 1'b1;
        end
        default: st_q <= XST_IDLE;
      endcase
    end
  end

  assign busy      = (st_q != XST_IDLE);
  assign done      = done_q;
  assign mem_re    = in_run && !store_q;
  assign mem_we    = in_run && store_q;
  assign mem_addr  = in_run ? (addr_q + MEM_AW'(cnt_q)) : '0;
  assign src_reg   = reg_q;
  assign src_byte  = cur_pos[BIDX_W-1:0];
  assign mem_wdata = mem_we ? rf_byte : 8'h00;
  assign wr_en     = pend_v_q && !pend_pos_q[BIDX_W];
  assign wr_reg    = reg_q;
  assign wr_byte   = pend_pos_q[BIDX_W-1:0];
  assign wr_data   = mem_rdata;
  assign nbytes    = nbytes_q;
  assign is_store  = store_q;

endmodule

// File: rtl/vlx_regfile.sv
module vlx_regfile
  import vlx_pkg::*;
#(
  parameter int NREGS  = 8,
  parameter int RBYTES = 16,
  parameter int RIDX_W = 3,
  parameter int BIDX_W = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                we,
  input  logic [RIDX_W-1:0]   widx,
  input  logic [BIDX_W-1:0]   wbyte,
  input  logic [7:0]          wdata,
  input  logic [RIDX_W-1:0]   bidx,
  input  logic [BIDX_W-1:0]   bsel,
  output logic [7:0]          bdata,
  input  logic [RIDX_W-1:0]   fidx,
  output logic [RBYTES*8-1:0] fdata
);

  logic [7:0] bytes_q [NREGS][RBYTES];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int r = 0; r < NREGS; r++) begin
        for (int b = 0; b < RBYTES; b++) begin
          bytes_q[r][b] <= 8'h00;
        end
      end
    end else if (we) begin
      bytes_q[widx][wbyte] <= wdata;
    end
  end

  assign bdata = bytes_q[bidx][bsel];

  for (genvar gb = 0; gb < RBYTES; gb++) begin : g_pack
    assign fdata[byte_lsb(RBYTES, gb) +: 8] = bytes_q[fidx][gb];
  end

endmodule

// File: rtl/vlx_top.sv
module vlx_top
  import vlx_pkg::*;
#(
  parameter int NREGS  = 8,
  parameter int LANES  = 8,
  parameter int BASE_W = 32,
  parameter int OFF_W  = 7,
  parameter int MEM_AW = 12,
  localparam int RBYTES = LANES * 2,
  localparam int RW     = RBYTES * 8,
  localparam int RIDX_W = $clog2(NREGS),
  localparam int BIDX_W = $clog2(RBYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              op_store,
  input  logic [1:0]        op_size,
  input  logic [BASE_W-1:0] base_val,
  input  logic [OFF_W-1:0]  offset,
  input  logic [RIDX_W-1:0] vreg,
  input  logic [BIDX_W-1:0] elem,
  output logic              busy,
  output logic              done,
  output logic [MEM_AW-1:0] mem_addr,
  output logic              mem_re,
  output logic              mem_we,
  output logic [7:0]        mem_wdata,
  input  logic [7:0]        mem_rdata,
  input  logic [RIDX_W-1:0] rf_rd_idx,
  output logic [RW-1:0]     rf_rd_data
);

  xsize_e            size_code;
  logic [MEM_AW-1:0] first_addr;
  logic [7:0]        src_data;
  logic [RIDX_W-1:0] src_reg;
  logic [BIDX_W-1:0] src_byte;
  logic              rf_we;
  logic [RIDX_W-1:0] rf_wreg;
  logic [BIDX_W-1:0] rf_wbyte;
  logic [7:0]        rf_wdata;
  logic              xfer_accept;
  logic [3:0]        op_bytes;
  logic              op_is_store;

  assign size_code = xsize_e'(op_size);

  vlx_addr_gen #(
    .BASE_W (BASE_W),
    .OFF_W  (OFF_W),
    .MEM_AW (MEM_AW)
  ) u_addr (
    .base_val (base_val),
    .offset   (offset),
    .size     (size_code),
    .addr     (first_addr)
  );

  vlx_seq #(
    .MEM_AW (MEM_AW),
    .RIDX_W (RIDX_W),
    .BIDX_W (BIDX_W)
  ) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .op_store   (op_store),
    .op_size    (size_code),
    .start_addr (first_addr),
    .vreg       (vreg),
    .elem       (elem),
    .rf_byte    (src_data),
    .mem_rdata  (mem_rdata),
    .busy       (busy),
    .done       (done),
    .mem_addr   (mem_addr),
    .mem_re     (mem_re),
    .mem_we     (mem_we),
    .mem_wdata  (mem_wdata),
    .src_reg    (src_reg),
    .src_byte   (src_byte),
    .wr_en      (rf_we),
    .wr_reg     (rf_wreg),
    .wr_byte    (rf_wbyte),
    .wr_data    (rf_wdata),
    .accept     (xfer_accept),
    .nbytes     (op_bytes),
    .is_store   (op_is_store)
  );

  vlx_regfile #(
    .NREGS  (NREGS),
    .RBYTES (RBYTES),
    .RIDX_W (RIDX_W),
    .BIDX_W (BIDX_W)
  ) u_rf (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (rf_we),
    .widx  (rf_wreg),
    .wbyte (rf_wbyte),
    .wdata (rf_wdata),
    .bidx  (src_reg),
    .bsel  (src_byte),
    .bdata (src_data),
    .fidx  (rf_rd_idx),
    .fdata (rf_rd_data)
  );

endmodule

// File: rtl/vlx_checker.sv
module vlx_checker #(
  parameter int MEM_AW = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              done,
  input logic              mem_re,
  input logic              mem_we,
  input logic [MEM_AW-1:0] mem_addr,
  input logic              accept,
  input logic [3:0]        op_bytes,
  input logic              rf_we,
  input logic              op_is_store
);

  logic       strobe;
  logic [4:0] strobe_cnt;

  assign strobe = mem_re || mem_we;

  always_ff @(posedge clk) begin
    if (!rst_n)      strobe_cnt <= '0;
    else if (done)   strobe_cnt <= '0;
    else if (strobe) strobe_cnt <= strobe_cnt + 5'd1;
  end

  // R7: completion is a single-cycle pulse
  a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R7: busy is low when done is reported
  a_r7_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R7: memory strobes only inside an operation, never both at once
  a_r7_strobe_busy: assert property (@(posedge clk) disable iff (!rst_n)
    strobe |-> (busy && !(mem_re && mem_we)));

  // R2: access count matches the size of the finished operation
  a_r2_byte_count: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (strobe_cnt == {1'b0, op_bytes}));

  // R6: consecutive accesses step the address by one, modulo memory size
  a_r6_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && $past(strobe)) |-> (mem_addr == MEM_AW'($past(mem_addr) + 1'b1)));

  // R4: the register file is written only by loads
  a_r4_load_writes_only: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we |-> !op_is_store);

  // R8: a command is only taken while idle
  a_r8_accept_idle: assert property (@(posedge clk) disable iff (!rst_n)
    accept |-> !busy);

endmodule

bind vlx_top vlx_checker #(.MEM_AW(MEM_AW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .busy        (busy),
  .done        (done),
  .mem_re      (mem_re),
  .mem_we      (mem_we),
  .mem_addr    (mem_addr),
  .accept      (xfer_accept),
  .op_bytes    (op_bytes),
  .rf_we       (rf_we),
  .op_is_store (op_is_store)
);

// File: tb/vlx_top_bench.sv
module vlx_top_bench;

  localparam int CLK_PERIOD = 10;
  localparam int NV = 13;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic         op_store = 1'b0;
  logic [1:0]   op_size = '0;
  logic [31:0]  base_val = '0;
  logic [6:0]   offset = '0;
  logic [2:0]   vreg = '0;
  logic [3:0]   elem = '0;
  logic         busy, done, mem_re, mem_we;
  logic [11:0]  mem_addr;
  logic [7:0]   mem_wdata;
  logic [7:0]   mem_rdata = '0;
  logic [2:0]   rf_rd_idx = '0;
  logic [127:0] rf_rd_data;

  logic [7:0] mem  [4096];
  logic [7:0] emem [4096];
  logic [7:0] ereg [8][16];

  int checks = 0;
  int fails = 0;
  int strobes = 0;
  int first_addr = 0;

  // fields: store, size, base[15:0], offset, reg, elem
  localparam logic [32:0] VEC [NV] = '{
    {1'b0, 2'd0, 16'h0100, 7'd0,   3'd1, 4'd8 },  // R3 byte into high half of lane 4
    {1'b0, 2'd1, 16'h0200, 7'd3,   3'd1, 4'd4 },  // R3 halfword into lane 2, scaled offset
    {1'b0, 2'd2, 16'h0300, 7'h7F,  3'd2, 4'd6 },  // R3 word spills into lane 4, negative offset
    {1'b0, 2'd3, 16'h0010, 7'd2,   3'd3, 4'd0 },  // R3 doubleword
    {1'b0, 2'd3, 16'h0400, 7'd0,   3'd3, 4'd12},  // R4 positions 16..19 dropped
    {1'b0, 2'd3, 16'h0FFC, 7'd0,   3'd4, 4'd0 },  // R6 memory wrap on load
    {1'b0, 2'd3, 16'h0000, 7'h7F,  3'd5, 4'd2 },  // R1 offset -1 from zero gives 0xFF8
    {1'b1, 2'd0, 16'h0500, 7'd1,   3'd1, 4'd8 },  // R5 byte store
    {1'b1, 2'd1, 16'h0510, 7'd0,   3'd2, 4'd6 },  // R5 halfword store
    {1'b1, 2'd2, 16'h0520, 7'd63,  3'd3, 4'd4 },  // R1 largest positive offset
    {1'b1, 2'd3, 16'h0600, 7'd0,   3'd3, 4'd12},  // R5 register index wraps 15 to 0
    {1'b1, 2'd3, 16'h0FFE, 7'd0,   3'd4, 4'd0 },  // R6 memory wrap on store
    {1'b0, 2'd2, 16'hA010, 7'd0,   3'd6, 4'd1 }   // R1 base bits above 11 ignored
  };

  function automatic string vtag(input int i);
    case (i)
      4:       return "R4";
      5, 11:   return "R6";
      6, 9, 12: return "R1";
      7, 8, 10: return "R5";
      default: return "R3";
    endcase
  endfunction

  vlx_top u_vlx_top (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .op_store   (op_store),
    .op_size    (op_size),
    .base_val   (base_val),
    .offset     (offset),
    .vreg       (vreg),
    .elem       (elem),
    .busy       (busy),
    .done       (done),
    .mem_addr   (mem_addr),
    .mem_re     (mem_re),
    .mem_we     (mem_we),
    .mem_wdata  (mem_wdata),
    .mem_rdata  (mem_rdata),
    .rf_rd_idx  (rf_rd_idx),
    .rf_rd_data (rf_rd_data)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // synchronous byte memory with one-cycle read latency
  always @(posedge clk) begin
    if (mem_we) mem[mem_addr] <= mem_wdata;
    if (mem_re) mem_rdata <= mem[mem_addr];
    if (mem_re || mem_we) begin
      if (strobes == 0) first_addr = int'(mem_addr);
      strobes = strobes + 1;
    end
  end

  task automatic chk(input bit ok, input string tag,
                     input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic int eff(input logic [31:0] b, input logic [6:0] o, input int n);
    int so;
    so = (o >= 7'd64) ? int'(o) - 128 : int'(o);
    return (int'(b) + so * n) & 32'hFFF;
  endfunction

  task automatic model(input bit st, input int n, input int a, input int rg, input int el);
    for (int k = 0; k < n; k++) begin
      if (!st) begin
        if (el + k < 16) ereg[rg][el + k] = emem[(a + k) & 'hFFF];
      end else begin
        emem[(a + k) & 'hFFF] = ereg[rg][(el + k) % 16];
      end
    end
  endtask

  task automatic check_regs(input int rg, input string tag);
    logic [127:0] ex;
    for (int r = 0; r < 8; r++) begin
      rf_rd_idx = 3'(r);
      #1;
      for (int b = 0; b < 16; b++) ex[(15 - b) * 8 +: 8] = ereg[r][b];
      chk(rf_rd_data == ex, (r == rg) ? tag : "R8", rf_rd_data, ex);
    end
  endtask

  task automatic check_mem(input int a, input int n, input string tag);
    for (int k = -1; k <= n; k++) begin
      int ix;
      ix = (a + k) & 'hFFF;
      chk(mem[ix] == emem[ix], tag, 128'(mem[ix]), 128'(emem[ix]));
    end
  endtask

  // runs one command; returns busy cycle count
  task automatic run_op(input bit st, input logic [1:0] sz, input logic [31:0] b,
                        input logic [6:0] o, input logic [2:0] rg, input logic [3:0] el,
                        output int bcyc);
    int guard;
    @(negedge clk);
    strobes  = 0;
    op_store = st;  op_size = sz;  base_val = b;
    offset   = o;   vreg = rg;     elem = el;
    start    = 1'b1;
    @(negedge clk);
    start = 1'b0;
    bcyc  = busy ? 1 : 0;
    guard = 0;
    while (!done && guard < 40) begin
      @(negedge clk);
      if (busy) bcyc++;
      guard++;
    end
    chk(done && !busy, "R7", {126'd0, done, busy}, 128'd2);
    @(negedge clk);
    chk(!done, "R7", 128'(done), 128'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL R7 watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int bc;
    for (int i = 0; i < 4096; i++) begin
      mem[i]  = 8'(i * 7 + 3);
      emem[i] = 8'(i * 7 + 3);
    end
    for (int r = 0; r < 8; r++)
      for (int b = 0; b < 16; b++) ereg[r][b] = 8'h00;

    repeat (3) @(negedge clk);
    // R9: state during and after reset
    chk(!busy && !done && !mem_re && !mem_we, "R9",
        {124'd0, busy, done, mem_re, mem_we}, 128'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !done && !mem_re && !mem_we, "R9",
        {124'd0, busy, done, mem_re, mem_we}, 128'd0);
    check_regs(0, "R9");

    for (int i = 0; i < NV; i++) begin
      bit          st;
      logic [1:0]  sz;
      logic [15:0] b;
      logic [6:0]  o;
      logic [2:0]  rg;
      logic [3:0]  el;
      int          n, a;
      {st, sz, b, o, rg, el} = VEC[i];
      n = 1 << sz;
      a = eff({16'h0, b}, o, n);
      model(st, n, a, int'(rg), int'(el));
      run_op(st, sz, {16'h0, b}, o, rg, el, bc);
      chk(first_addr == a, "R1", 128'(first_addr), 128'(a));
      chk(strobes == n, "R2", 128'(strobes), 128'(n));
      chk(bc == (st ? n : n + 1), "R7", 128'(bc), 128'(st ? n : n + 1));
      check_regs(int'(rg), vtag(i));
      if (st) check_mem(a, n, vtag(i));
    end

    // R8: second start one cycle into a running load is ignored
    @(negedge clk);
    strobes  = 0;
    op_store = 1'b0; op_size = 2'd0; base_val = 32'h700; offset = 7'd0;
    vreg = 3'd7; elem = 4'd0; start = 1'b1;
    @(negedge clk);
    op_store = 1'b1; op_size = 2'd3; base_val = 32'h710; vreg = 3'd7; elem = 4'd0;
    @(negedge clk);
    start = 1'b0;
    begin
      int guard;
      guard = 0;
      while (!done && guard < 40) begin
        @(negedge clk);
        guard++;
      end
    end
    model(1'b0, 1, 'h700, 7, 0);
    chk(strobes == 1, "R8", 128'(strobes), 128'd1);
    check_mem('h710, 8, "R8");
    check_regs(7, "R8");

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule